// File: doc/BRIEF.md
# All-or-Nothing Fetch Group Queue

This block is a small front-end buffer that sits between instruction fetch and the dispatch stage. Every cycle fetch may offer a group of one to four instructions. The group is written into the queue only when all of its instructions fit into the space that was free at the start of the cycle. Otherwise the whole group is refused, and a stall output tells fetch to offer it again.

In the same cycle the queue releases up to a fixed number of its oldest instructions, strictly in program order. Each instruction carries a one-bit class tag that routes it either to a scalar dispatch queue or to a vector dispatch queue. Each dispatch queue reports how many slots it can take in the current cycle. The release stops at the first instruction whose destination has no slot left, even when younger instructions could go to the other destination. Each destination receives its instructions packed into lanes, oldest in lane 0, together with a count.

Top module: `fetch_group_queue`

## Requirements
- R1: After reset the queue is empty: both dispatch counts are 0, no stall is raised, and a full group of four is accepted in the first cycle.
- R2: A valid group of n instructions (fetch_count = n, 1 <= n <= 4) is stored completely when n is at most the number of free entries (4 minus occupancy) at the start of the cycle. Otherwise none of it is stored and fetch_stall is 1 in that cycle.
- R3: Entries released by the drain in a cycle do not count as free space for the group offered in that same cycle.
- R4: Instructions are released oldest first, at most 4 per cycle. Within each destination, lane k (bits k*32 +: 32) carries the k-th released instruction, and the count output tells how many lanes are valid.
- R5: Group slot k is bits k*32 +: 32 of fetch_data and bit k of fetch_class, and slot 0 is the oldest. A class bit of 0 routes the instruction to the scalar destination and 1 routes it to the vector destination.
- R6: The drain stops at the first instruction whose destination has no remaining slot this cycle, where the remaining slots are the free input minus what that destination has already received this cycle. No younger instruction leaves in that cycle.
- R7: The count sent to each destination never exceeds that destination's free input.
- R8: With fetch_valid low, or with fetch_count 0, nothing is stored and fetch_stall is 0.
- R9: A valid offer with fetch_count above 4 stores nothing and raises fetch_stall.
- R10: Every accepted instruction leaves exactly once. Accepted groups are placed behind the instructions already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_valid | input | 1 | A fetch group is offered this cycle |
| fetch_count | input | 3 | Number of instructions in the offered group |
| fetch_data | input | 128 | Four 32-bit instruction slots, slot 0 oldest |
| fetch_class | input | 4 | Class bit per slot (0 scalar, 1 vector) |
| fetch_stall | output | 1 | The offered group was refused this cycle |
| sc_free | input | 3 | Slots the scalar dispatch queue accepts this cycle |
| sc_cnt | output | 3 | Number of instructions sent to the scalar destination |
| sc_data | output | 128 | Scalar lanes, lane 0 oldest |
| vc_free | input | 3 | Slots the vector dispatch queue accepts this cycle |
| vc_cnt | output | 3 | Number of instructions sent to the vector destination |
| vc_data | output | 128 | Vector lanes, lane 0 oldest |

## Verification
A group can be offered in the same cycle that the drain releases entries. The interesting case is a full or nearly full queue that drains while fetch presents a group which would fit only if the freed entries were counted. The bench provokes this by filling the queue with the destinations held at zero, then opening the destinations while offering a group. It judges the result by the stall output in that cycle and by the instructions that come out afterwards, which are compared against a scoreboard that holds only the groups predicted as accepted from the start-of-cycle occupancy.

// File: rtl/fgq_pkg.sv
package fgq_pkg;

  typedef enum logic {
    CLS_SCALAR = 1'b0,
    CLS_VECTOR = 1'b1
  } ins_class_e;

  // Ring index: base + off folded once into [0, depth). Requires off <= depth.
  function automatic int ring_idx(int base, int off, int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/fgq_admit.sv
module fgq_admit #(
  parameter int GROUP_MAX = 4,
  parameter int DEPTH     = 4,
  parameter int CNT_W     = 3,
  parameter int OCC_W     = 3
) (
  input  logic             fetch_valid,
  input  logic [CNT_W-1:0] fetch_count,
  input  logic [OCC_W-1:0] occ,
  output logic             accept,
  output logic             stall
);

  int   free_slots;
  int   want;
  logic offered;
  logic fits;

  // Space is judged on start-of-cycle occupancy only.
  always_comb begin
    free_slots = DEPTH - int'(occ);
    want       = int'(fetch_count);
    offered    = fetch_valid && (want != 0);
    fits       = (want <= GROUP_MAX) && (want <= free_slots);
    accept     = offered && fits;
    stall      = offered && !fits;
  end

endmodule

// File: rtl/fgq_ring.sv
module fgq_ring
  import fgq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int GROUP_MAX = 4,
  parameter int CNT_W     = 3,
  parameter int OCC_W     = 3,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [CNT_W-1:0]            wr_cnt,
  input  logic [GROUP_MAX*DATA_W-1:0] wr_data,
  input  logic [GROUP_MAX-1:0]        wr_cls,
  input  logic [OCC_W-1:0]            pop_cnt,
  output logic [OCC_W-1:0]            occ,
  output logic [DEPTH*DATA_W-1:0]     view_data,
  output logic [DEPTH-1:0]            view_cls
);

  logic [DATA_W-1:0] mem_q  [DEPTH];
  logic              cls_q  [DEPTH];
  logic [PTR_W-1:0]  head_q;
  logic [OCC_W-1:0]  occ_q;

  logic [PTR_W-1:0]  head_d;
  logic [OCC_W-1:0]  occ_d;
  logic              slot_we    [DEPTH];
  logic [DATA_W-1:0] slot_wdata [DEPTH];
  logic              slot_wcls  [DEPTH];
  logic [PTR_W-1:0]  widx;

  // Next-state: write the accepted group behind the held entries, retire the head.
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      slot_we[s]    = 1'b0;
      slot_wdata[s] = '0;
      slot_wcls[s]  = 1'b0;
    end
    widx = '0;
    for (int j = 0; j < GROUP_MAX; j++) begin
      if (wr_en && (j < int'(wr_cnt)) && (int'(occ_q) + j < DEPTH)) begin
        widx             = PTR_W'(ring_idx(int'(head_q), int'(occ_q) + j, DEPTH));
        slot_we[widx]    = 1'b1;
        slot_wdata[widx] = wr_data[j*DATA_W +: DATA_W];
        slot_wcls[widx]  = wr_cls[j];
      end
    end
    head_d = PTR_W'(ring_idx(int'(head_q), int'(pop_cnt), DEPTH));
    occ_d  = OCC_W'(int'(occ_q) - int'(pop_cnt) + (wr_en ? int'(wr_cnt) : 0));
  end

  // Control state: reset to empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_d;
      occ_q  <= occ_d;
    end
  end

  // Payload storage: no reset, per-slot write enable.
  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (slot_we[s]) begin
        mem_q[s] <= slot_wdata[s];
        cls_q[s] <= slot_wcls[s];
      end
    end
  end

  assign occ = occ_q;

  // Head-relative view: entry i is the i-th oldest.
  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    logic [PTR_W-1:0] ridx;
    assign ridx = PTR_W'(ring_idx(int'(head_q), i, DEPTH));
    assign view_data[i*DATA_W +: DATA_W] = mem_q[ridx];
    assign view_cls[i]                   = cls_q[ridx];
  end

endmodule

// File: rtl/fgq_drain.sv
module fgq_drain
  import fgq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int DRAIN_MAX = 4,
  parameter int OCC_W     = 3,
  parameter int DRN_W     = 3,
  localparam int LANES    = (DRAIN_MAX < DEPTH) ? DRAIN_MAX : DEPTH
) (
  input  logic [OCC_W-1:0]            occ,
  input  logic [DEPTH*DATA_W-1:0]     view_data,
  input  logic [DEPTH-1:0]            view_cls,
  input  logic [DRN_W-1:0]            sc_free,
  input  logic [DRN_W-1:0]            vc_free,
  output logic [DRN_W-1:0]            sc_cnt,
  output logic [DRN_W-1:0]            vc_cnt,
  output logic [DRAIN_MAX*DATA_W-1:0] sc_data,
  output logic [DRAIN_MAX*DATA_W-1:0] vc_data,
  output logic [OCC_W-1:0]            pop_cnt
);

  int   sn;
  int   vn;
  int   scr;
  int   vcr;
  logic blocked;

  // In-order walk from the head; the first instruction without a slot blocks the rest.
  always_comb begin
    sc_data = '0;
    vc_data = '0;
    sn      = 0;
    vn      = 0;
    scr     = int'(sc_free);
    vcr     = int'(vc_free);
    blocked = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!blocked && (i < int'(occ))) begin
        if (view_cls[i] == CLS_VECTOR) begin
          if (vcr > 0) begin
            vc_data[vn*DATA_W +: DATA_W] = view_data[i*DATA_W +: DATA_W];
            vn  = vn + 1;
            vcr = vcr - 1;
          end else begin
            blocked = 1'b1;
          end
        end else begin
          if (scr > 0) begin
            sc_data[sn*DATA_W +: DATA_W] = view_data[i*DATA_W +: DATA_W];
            sn  = sn + 1;
            scr = scr - 1;
          end else begin
            blocked = 1'b1;
          end
        end
      end
    end
    sc_cnt  = DRN_W'(sn);
    vc_cnt  = DRN_W'(vn);
    pop_cnt = OCC_W'(sn + vn);
  end

endmodule

// File: rtl/fetch_group_queue.sv
module fetch_group_queue #(
  parameter int DATA_W    = 32,
  parameter int GROUP_MAX = 4,
  parameter int DEPTH     = 4,
  parameter int DRAIN_MAX = 4,
  localparam int CNT_W    = $clog2(GROUP_MAX + 4),
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int DRN_W    = $clog2(DRAIN_MAX + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_valid,
  input  logic [CNT_W-1:0]            fetch_count,
  input  logic [GROUP_MAX*DATA_W-1:0] fetch_data,
  input  logic [GROUP_MAX-1:0]        fetch_class,
  output logic                        fetch_stall,
  input  logic [DRN_W-1:0]            sc_free,
  output logic [DRN_W-1:0]            sc_cnt,
  output logic [DRAIN_MAX*DATA_W-1:0] sc_data,
  input  logic [DRN_W-1:0]            vc_free,
  output logic [DRN_W-1:0]            vc_cnt,
  output logic [DRAIN_MAX*DATA_W-1:0] vc_data
);

  logic [OCC_W-1:0]        occ;
  logic [OCC_W-1:0]        pop_cnt;
  logic [DEPTH*DATA_W-1:0] view_data;
  logic [DEPTH-1:0]        view_cls;
  logic                    accept;

  fgq_admit #(
    .GROUP_MAX (GROUP_MAX),
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W),
    .OCC_W     (OCC_W)
  ) u_admit (
    .fetch_valid (fetch_valid),
    .fetch_count (fetch_count),
    .occ         (occ),
    .accept      (accept),
    .stall       (fetch_stall)
  );

  fgq_ring #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .GROUP_MAX (GROUP_MAX),
    .CNT_W     (CNT_W),
    .OCC_W     (OCC_W)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept),
    .wr_cnt    (fetch_count),
    .wr_data   (fetch_data),
    .wr_cls    (fetch_class),
    .pop_cnt   (pop_cnt),
    .occ       (occ),
    .view_data (view_data),
    .view_cls  (view_cls)
  );

  fgq_drain #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .DRAIN_MAX (DRAIN_MAX),
    .OCC_W     (OCC_W),
    .DRN_W     (DRN_W)
  ) u_drain (
    .occ       (occ),
    .view_data (view_data),
    .view_cls  (view_cls),
    .sc_free   (sc_free),
    .vc_free   (vc_free),
    .sc_cnt    (sc_cnt),
    .vc_cnt    (vc_cnt),
    .sc_data   (sc_data),
    .vc_data   (vc_data),
    .pop_cnt   (pop_cnt)
  );

endmodule

// File: rtl/fgq_chk.sv
module fgq_chk #(
  parameter int DEPTH     = 4,
  parameter int DRAIN_MAX = 4,
  parameter int CNT_W     = 3,
  parameter int OCC_W     = 3,
  parameter int DRN_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic [CNT_W-1:0] fetch_count,
  input logic             fetch_stall,
  input logic [DRN_W-1:0] sc_free,
  input logic [DRN_W-1:0] vc_free,
  input logic [DRN_W-1:0] sc_cnt,
  input logic [DRN_W-1:0] vc_cnt,
  input logic [OCC_W-1:0] occ,
  input logic             head_cls
);

  a_r7_sc_credit: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sc_cnt) <= int'(sc_free));

  a_r7_vc_credit: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vc_cnt) <= int'(vc_free));

  a_r4_drain_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sc_cnt) + int'(vc_cnt) <= int'(occ)) &&
    (int'(sc_cnt) + int'(vc_cnt) <= DRAIN_MAX));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  a_r2_refused_stores_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> int'(occ) == int'($past(occ)) - int'($past(sc_cnt)) - int'($past(vc_cnt)));

  a_r8_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid || fetch_count == '0) |-> !fetch_stall);

  a_r6_head_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0 && head_cls == 1'b0 && sc_free == '0) |-> (sc_cnt == '0 && vc_cnt == '0));

  a_r6_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0 && head_cls == 1'b1 && vc_free != '0) |-> (vc_cnt != '0));

endmodule

bind fetch_group_queue fgq_chk #(
  .DEPTH     (DEPTH),
  .DRAIN_MAX (DRAIN_MAX),
  .CNT_W     (CNT_W),
  .OCC_W     (OCC_W),
  .DRN_W     (DRN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_count (fetch_count),
  .fetch_stall (fetch_stall),
  .sc_free     (sc_free),
  .vc_free     (vc_free),
  .sc_cnt      (sc_cnt),
  .vc_cnt      (vc_cnt),
  .occ         (occ),
  .head_cls    (view_cls[0])
);

// File: tb/fetch_group_queue_tb.sv
module fetch_group_queue_tb;

  logic         clk;
  logic         rst_n;
  logic         fetch_valid;
  logic [2:0]   fetch_count;
  logic [127:0] fetch_data;
  logic [3:0]   fetch_class;
  logic         fetch_stall;
  logic [2:0]   sc_free;
  logic [2:0]   sc_cnt;
  logic [127:0] sc_data;
  logic [2:0]   vc_free;
  logic [2:0]   vc_cnt;
  logic [127:0] vc_data;

  int checks;
  int failures;
  int nid;
  logic [32:0] mq [$];  // scoreboard: {class, data}, oldest first

  fetch_group_queue u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_count (fetch_count),
    .fetch_data  (fetch_data),
    .fetch_class (fetch_class),
    .fetch_stall (fetch_stall),
    .sc_free     (sc_free),
    .sc_cnt      (sc_cnt),
    .sc_data     (sc_data),
    .vc_free     (vc_free),
    .vc_cnt      (vc_cnt),
    .vc_data     (vc_data)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver + monitor for one cycle. stag names the stall check, dtag the drain checks.
  task automatic step(input bit v, input int cnt, input logic [3:0] cls,
                      input int scf, input int vcf, input string stag, input string dtag);
    bit          exp_stall, exp_acc, stop;
    int          scr, vcr, esn, evn, taken, start_sz;
    logic [31:0] esc [4];
    logic [31:0] evc [4];
    logic [127:0] d;
    @(negedge clk);
    for (int k = 0; k < 4; k++) d[k*32 +: 32] = 32'(nid + k);
    nid += 4;
    fetch_valid = v;
    fetch_count = 3'(cnt);
    fetch_data  = d;
    fetch_class = cls;
    sc_free     = 3'(scf);
    vc_free     = 3'(vcf);
    #1ns;
    start_sz  = mq.size();
    exp_acc   = v && cnt != 0 && cnt <= 4 && cnt <= 4 - start_sz;
    exp_stall = v && cnt != 0 && !exp_acc;
    chk(fetch_stall == exp_stall, {stag, " stall"}, longint'(fetch_stall), longint'(exp_stall));
    scr = scf; vcr = vcf; esn = 0; evn = 0; taken = 0; stop = 0;
    for (int i = 0; i < 4 && i < start_sz; i++) begin
      if (!stop) begin
        if (mq[i][32]) begin
          if (vcr > 0) begin evc[evn] = mq[i][31:0]; evn++; vcr--; taken++; end
          else stop = 1;
        end else begin
          if (scr > 0) begin esc[esn] = mq[i][31:0]; esn++; scr--; taken++; end
          else stop = 1;
        end
      end
    end
    chk(int'(sc_cnt) == esn, {dtag, " scalar count"}, longint'(sc_cnt), longint'(esn));
    chk(int'(vc_cnt) == evn, {dtag, " vector count"}, longint'(vc_cnt), longint'(evn));
    for (int k = 0; k < esn; k++)
      chk(sc_data[k*32 +: 32] == esc[k], {dtag, " scalar lane"}, longint'(sc_data[k*32 +: 32]), longint'(esc[k]));
    for (int k = 0; k < evn; k++)
      chk(vc_data[k*32 +: 32] == evc[k], {dtag, " vector lane"}, longint'(vc_data[k*32 +: 32]), longint'(evc[k]));
    @(posedge clk);
    for (int i = 0; i < taken; i++) void'(mq.pop_front());
    if (exp_acc)
      for (int k = 0; k < cnt; k++) mq.push_back({cls[k], d[k*32 +: 32]});
  endtask

  initial begin
    #600us;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; nid = 32'h100;
    rst_n = 1'b0; fetch_valid = 0; fetch_count = 0; fetch_data = '0;
    fetch_class = 0; sc_free = 0; vc_free = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then a full group accepted into the empty queue
    step(0, 0, 4'b0000, 4, 4, "R1", "R1");
    step(1, 4, 4'b0110, 0, 0, "R1", "R1");
    // R2: full queue refuses a single instruction; R7: zero credit sends nothing
    step(1, 1, 4'b0000, 0, 0, "R2", "R7");
    // R3: drain of all four in the same cycle does not make room; R5 routing
    step(1, 2, 4'b0000, 4, 4, "R3", "R5");
    // Load [S,V,S,S]
    step(1, 4, 4'b0010, 0, 0, "R2", "R7");
    // R6: scalar credit 1 -> S,V leave, stop at second S
    step(0, 0, 4'b0000, 1, 4, "R8", "R6");
    // R2: occupancy 2, group of 3 refused
    step(1, 3, 4'b0000, 0, 0, "R2", "R7");
    // R2: group of 2 vectors fits exactly; R6: head scalar blocked with no credit
    step(1, 2, 4'b0011, 0, 4, "R2", "R6");
    // R9: count 5 refused; R4: two scalars then vector blocked
    step(1, 5, 4'b0000, 2, 0, "R9", "R4");
    // R8: valid low is not stored; remaining vectors drain
    step(0, 4, 4'b1111, 4, 4, "R8", "R10");
    step(1, 0, 4'b1111, 4, 4, "R8", "R8");
    step(0, 0, 4'b0000, 4, 4, "R8", "R8");
    // R10: group stored behind held entries
    step(1, 3, 4'b0101, 4, 4, "R2", "R10");
    step(1, 1, 4'b0000, 4, 4, "R3", "R4");
    step(0, 0, 4'b0000, 4, 4, "R10", "R10");
    // R7: four scalars, scalar credit 2
    step(1, 4, 4'b0000, 0, 0, "R2", "R7");
    step(0, 0, 4'b0000, 2, 0, "R8", "R7");
    step(0, 0, 4'b0000, 4, 4, "R8", "R4");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 3) != 0, int'($urandom_range(0, 5)), 4'($urandom),
           int'($urandom_range(0, 4)), int'($urandom_range(0, 4)), "R2", "R6");
    end
    // Flush and confirm nothing is left or duplicated
    repeat (3) step(0, 0, 4'b0000, 4, 4, "R10", "R10");
    chk(mq.size() == 0, "R10 flushed", longint'(mq.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule